// File: doc/BRIEF.md
# Two-wire programming-port frame master

This block is the host side of a two-wire debug and programming link. One wire is a clock that only the host drives. The other is a data wire shared by host and target, so its direction changes from one field of a frame to the next. A host request carries a 2-bit operation code and one byte, and selects one of four transactions: write the target's address register, read it back, write one data byte, or read one data byte. When the frame ends the block pulses `done`, updates an error flag and, for reads, presents the received byte.

Every clock pulse is a short high-low-high strobe, because a long low phase on the clock wire means "reset" to the target. The block can also produce that reset on purpose: a dedicated request holds the clock low for a long, fixed time. A prescaler parameter turns system clock cycles into link phase lengths.

Data frames contain a wait field. During it the host releases the data wire and keeps strobing until the target pulls the wire high. The number of such strobes has a limit, and reaching it ends the frame with an error.

Top module: `pgm_link_master`

## Requirements
- R1: After reset, and from the second clock edge after `port_en` goes low, both `ck_oe` and `dat_oe` are 0. After reset `busy` and `done` are 0 and `ck_o` is 1.
- R2: `ck_oe` rises one cycle after `port_en` rises. In that cycle `ck_o` is already 1 and `dat_oe` is 0.
- R3: Every frame opens with one START strobe and closes with one STOP strobe, and data is released during both. The 2-bit instruction `req_op` is driven bit 0 first: 00 data read, 01 data write, 10 address read, 11 address write. Driven bits are valid at the clock's rising edge.
- R4: An address write (11) is 12 strobes long. It drives 1,1 and then `req_byte` LSB first.
- R5: An address read (10) is 12 strobes long. It drives 0,1, then releases data for 8 strobes. The level at the end of each strobe's high phase is taken LSB first and appears on `rd_byte`.
- R6: A data write (01) drives 1,0, the length code 0,0 and then `req_byte` LSB first. A wait field follows. If the target is high on wait strobe d (counting from 0), the frame is 15+d strobes long.
- R7: A data read (00) drives 0,0,0,0, then runs the wait field. If the target is high on wait strobe d, the next 8 strobes are sampled LSB first into `rd_byte`, and the frame is 15+d strobes long.
- R8: If data stays low for WAIT_LIMIT (20) wait strobes, the frame ends at once with no STOP, and `done` comes with `err`=1. That is 33 strobes for a data write and 25 for a data read.
- R9: In a frame, every clock low phase and every high phase between strobes lasts HALF_CYC cycles. The clock is never low longer than that except during a reset pulse.
- R10: `rst_req` while idle and enabled holds `ck_o` low for RST_TICKS*HALF_CYC cycles, then returns it high and pulses `done` with `err`=0. When `rst_req` and `req_valid` arrive in the same cycle, the reset wins.
- R11: `done` is high for exactly one cycle. `err` and `rd_byte` change only together with `done`. `rd_byte` changes only when a read frame completes its STOP.
- R12: A request is ignored while `busy` is high or while the port is disabled: no frame and no `done` result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Enables the link drivers |
| req_valid | input | 1 | Starts a frame when idle |
| req_op | input | 2 | Instruction code of the frame |
| req_byte | input | 8 | Address or data byte to send |
| rst_req | input | 1 | Requests a target reset pulse |
| busy | output | 1 | Frame or reset pulse in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Wait-field timeout on the last completion |
| rd_byte | output | 8 | Byte from the last completed read |
| ck_o | output | 1 | Link clock level |
| ck_oe | output | 1 | Link clock driver enable |
| dat_o | output | 1 | Link data level when driven |
| dat_oe | output | 1 | Link data driver enable |
| dat_i | input | 1 | Link data level seen at the pin |

## Verification
A reactive target model counts clock falls and answers each of the four instruction codes. Bytes with asymmetric bit patterns show bit order and field placement. Wait delays of 0, 7 and 19 strobes, plus a target that never answers, separate an early answer, a late one, the last allowed strobe and the timeout, each with its own expected strobe count. A reset pulse on its own, a reset colliding with a frame request, a request during a busy frame and a request with the port disabled show priority and the ignore rules. Clock phase lengths are measured in every frame to catch a stretched low phase.

// File: rtl/pgm_link_pkg.sv
package pgm_link_pkg;
  localparam int LINK_BYTE_W = 8;

  // Instruction codes; bit 1 set selects the address register.
  typedef enum logic [1:0] {
    OP_DRD = 2'b00,
    OP_DWR = 2'b01,
    OP_ARD = 2'b10,
    OP_AWR = 2'b11
  } link_op_e;

  typedef enum logic [3:0] {
    FLD_IDLE,
    FLD_START,
    FLD_INS,
    FLD_LEN,
    FLD_TX,
    FLD_RX,
    FLD_WAIT,
    FLD_STOP,
    FLD_RST
  } link_fld_e;
endpackage

// File: rtl/pgm_link_sync.sv
module pgm_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/pgm_link_tick.sv
module pgm_link_tick #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == CW'(HALF_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || at_end) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run & at_end;
endmodule

// File: rtl/pgm_link_seq.sv
module pgm_link_seq
  import pgm_link_pkg::*;
#(
  parameter int WAIT_LIMIT = 20,
  parameter int RST_TICKS  = 25
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   req_valid,
  input  logic [1:0]             req_op,
  input  logic [LINK_BYTE_W-1:0] req_byte,
  input  logic                   rst_req,
  input  logic                   tick,
  input  logic                   din,
  output logic                   busy,
  output logic                   phase_lo,
  output logic                   drive,
  output logic                   drive_val,
  output logic                   done,
  output logic                   err,
  output logic [LINK_BYTE_W-1:0] rd_byte,
  output logic                   rst_active
);
  localparam int CMAX = (WAIT_LIMIT > RST_TICKS) ? WAIT_LIMIT : RST_TICKS;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int BW   = $clog2(LINK_BYTE_W);

  link_fld_e              fld_q, fld_d;
  link_op_e               op_q, op_d;
  logic                   ph_q, ph_d;
  logic [BW-1:0]          bit_q, bit_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic [LINK_BYTE_W-1:0] sh_q, sh_d, rd_q, rd_d;
  logic                   done_q, done_d, err_q, err_d;
  logic [1:0]             op_bits;
  logic                   last_bit;

  assign op_bits  = op_q;
  assign last_bit = (bit_q == BW'(LINK_BYTE_W - 1));

  always_comb begin
    fld_d  = fld_q;  op_d   = op_q;  ph_d  = ph_q;  bit_d = bit_q;
    cnt_d  = cnt_q;  sh_d   = sh_q;  rd_d  = rd_q;  err_d = err_q;
    done_d = 1'b0;
    case (fld_q)
      FLD_IDLE: begin
        if (en && rst_req) begin
          fld_d = FLD_RST;  ph_d = 1'b1;  cnt_d = '0;
        end else if (en && req_valid) begin
          fld_d = FLD_START;  ph_d = 1'b1;  bit_d = '0;
          op_d  = link_op_e'(req_op);  sh_d = req_byte;
        end
      end
      FLD_RST: begin
        if (tick) begin
          if (cnt_q == CW'(RST_TICKS - 1)) begin
            fld_d = FLD_IDLE;  ph_d = 1'b0;  done_d = 1'b1;  err_d = 1'b0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        if (tick && ph_q) begin
          ph_d = 1'b0;                      // rising edge of the strobe
        end else if (tick) begin
          ph_d = 1'b1;                      // strobe over, next one starts
          case (fld_q)
            FLD_START: begin
              fld_d = FLD_INS;  bit_d = '0;
            end
            FLD_INS: begin
              if (bit_q[0]) begin
                bit_d = '0;
                if (op_bits[1]) fld_d = op_bits[0] ? FLD_TX : FLD_RX;
                else            fld_d = FLD_LEN;
              end else begin
                bit_d = 1;
              end
            end
            FLD_LEN: begin
              if (bit_q[0]) begin
                bit_d = '0;  cnt_d = '0;
                fld_d = (op_q == OP_DWR) ? FLD_TX : FLD_WAIT;
              end else begin
                bit_d = 1;
              end
            end
            FLD_TX: begin
              sh_d  = sh_q >> 1;
              bit_d = bit_q + 1'b1;
              if (last_bit) begin
                cnt_d = '0;
                fld_d = (op_q == OP_DWR) ? FLD_WAIT : FLD_STOP;
              end
            end
            FLD_RX: begin
              sh_d  = {din, sh_q[LINK_BYTE_W-1:1]};
              bit_d = bit_q + 1'b1;
              if (last_bit) fld_d = FLD_STOP;
            end
            FLD_WAIT: begin
              if (din) begin
                bit_d = '0;
                fld_d = (op_q == OP_DWR) ? FLD_STOP : FLD_RX;
              end else if (cnt_q == CW'(WAIT_LIMIT - 1)) begin
                fld_d = FLD_IDLE;  ph_d = 1'b0;  done_d = 1'b1;  err_d = 1'b1;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
            FLD_STOP: begin
              fld_d = FLD_IDLE;  ph_d = 1'b0;  done_d = 1'b1;  err_d = 1'b0;
              if (!op_bits[0]) rd_d = sh_q;
            end
            default: begin
              fld_d = FLD_IDLE;  ph_d = 1'b0;
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= FLD_IDLE;  op_q  <= OP_DRD;  ph_q   <= 1'b0;  bit_q <= '0;
      cnt_q  <= '0;        sh_q  <= '0;      rd_q   <= '0;
      done_q <= 1'b0;      err_q <= 1'b0;
    end else begin
      fld_q  <= fld_d;     op_q  <= op_d;    ph_q   <= ph_d;   bit_q <= bit_d;
      cnt_q  <= cnt_d;     sh_q  <= sh_d;    rd_q   <= rd_d;
      done_q <= done_d;    err_q <= err_d;
    end
  end

  always_comb begin
    drive     = 1'b0;
    drive_val = 1'b0;
    case (fld_q)
      FLD_INS: begin drive = 1'b1; drive_val = op_bits[bit_q[0]]; end
      FLD_LEN: begin drive = 1'b1; drive_val = 1'b0; end
      FLD_TX:  begin drive = 1'b1; drive_val = sh_q[0]; end
      default: ;
    endcase
  end

  assign busy       = (fld_q != FLD_IDLE);
  assign rst_active = (fld_q == FLD_RST);
  assign phase_lo   = ph_q;
  assign done       = done_q;
  assign err        = err_q;
  assign rd_byte    = rd_q;
endmodule

// File: rtl/pgm_link_master.sv
module pgm_link_master
  import pgm_link_pkg::*;
#(
  parameter int HALF_CYC    = 4,
  parameter int WAIT_LIMIT  = 20,
  parameter int RST_TICKS   = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   port_en,
  input  logic                   req_valid,
  input  logic [1:0]             req_op,
  input  logic [LINK_BYTE_W-1:0] req_byte,
  input  logic                   rst_req,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [LINK_BYTE_W-1:0] rd_byte,
  output logic                   ck_o,
  output logic                   ck_oe,
  output logic                   dat_o,
  output logic                   dat_oe,
  input  logic                   dat_i
);
  logic [1:0] rst_pipe_q;
  logic       srst_n;
  logic       en_q;
  logic       tick, din_s, phase_lo, drive, drive_val, rst_active;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) en_q <= 1'b0;
    else         en_q <= port_en;
  end

  pgm_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(srst_n), .d(dat_i), .q(din_s)
  );

  pgm_link_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk(clk), .rst_n(srst_n), .run(busy), .tick(tick)
  );

  pgm_link_seq #(.WAIT_LIMIT(WAIT_LIMIT), .RST_TICKS(RST_TICKS)) u_seq (
    .clk(clk), .rst_n(srst_n), .en(en_q), .req_valid(req_valid),
    .req_op(req_op), .req_byte(req_byte), .rst_req(rst_req),
    .tick(tick), .din(din_s), .busy(busy), .phase_lo(phase_lo),
    .drive(drive), .drive_val(drive_val), .done(done), .err(err),
    .rd_byte(rd_byte), .rst_active(rst_active)
  );

  assign ck_o   = ~phase_lo;
  assign ck_oe  = en_q;
  assign dat_oe = en_q & drive;
  assign dat_o  = drive & drive_val;
endmodule

// File: rtl/pgm_link_master_chk.sv
module pgm_link_master_chk #(
  parameter int HALF_CYC  = 4,
  parameter int RST_TICKS = 25
) (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic ck_o,
  input logic ck_oe,
  input logic dat_oe,
  input logic busy,
  input logic done,
  input logic err,
  input logic rst_active
);
  localparam int LMAX = RST_TICKS * HALF_CYC + 2;
  localparam int LW   = $clog2(LMAX + 1);

  logic [LW-1:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    lo_run <= '0;
    else if (ck_o)                 lo_run <= '0;
    else if (lo_run != LW'(LMAX))  lo_run <= lo_run + 1'b1;
  end

  assert_hiz_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!ck_oe && !dat_oe));

  assert_clk_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ck_oe) |-> (ck_o && !dat_oe));

  assert_drive_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> (busy && !rst_active));

  assert_short_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ck_o && lo_run >= LW'(HALF_CYC)) |-> rst_active);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err) |-> done);
endmodule

bind pgm_link_master pgm_link_master_chk #(
  .HALF_CYC(HALF_CYC), .RST_TICKS(RST_TICKS)
) u_chk (
  .clk(clk), .rst_n(srst_n), .port_en(port_en), .ck_o(ck_o), .ck_oe(ck_oe),
  .dat_oe(dat_oe), .busy(busy), .done(done), .err(err), .rst_active(rst_active)
);

// File: tb/pgm_link_master_test.sv
`timescale 1ns/1ps
module pgm_link_master_test;
  localparam int HALF = 4;
  localparam int RSTT = 25;
  localparam int WLIM = 20;

  logic       clk = 1'b0;
  logic       rst_n, port_en, req_valid, rst_req;
  logic [1:0] req_op;
  logic [7:0] req_byte;
  logic       busy, done, err, ck_o, ck_oe, dat_o, dat_oe;
  logic [7:0] rd_byte;
  logic       dat_i = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  pgm_link_master #(.HALF_CYC(HALF), .WAIT_LIMIT(WLIM), .RST_TICKS(RSTT)) uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .req_valid(req_valid),
    .req_op(req_op), .req_byte(req_byte), .rst_req(rst_req), .busy(busy),
    .done(done), .err(err), .rd_byte(rd_byte), .ck_o(ck_o), .ck_oe(ck_oe),
    .dat_o(dat_o), .dat_oe(dat_oe), .dat_i(dat_i)
  );

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  typedef struct {
    bit         is_rst;
    int         strobes;
    int         nbits;
    logic [31:0] bits;
    bit         err;
    logic [7:0] rd;
    int         lo;
  } item_t;

  item_t sbq[$];
  string tagq[$];
  logic [7:0] last_rd = 8'h00;

  // ---------------- target model ----------------
  logic [1:0] t_op = 2'b11;
  logic [7:0] t_b  = 8'h00;
  int         t_d  = 0;
  int fall_total = 0, fall_base = 0;
  int cap_total = 0, cap_base = 0;
  logic [31:0] cap = 32'h0;

  function automatic logic tgt_bit(input int idx);
    logic v;
    v = 1'b0;
    case (t_op)
      2'b10: if (idx >= 3 && idx <= 10) v = t_b[idx-3];
      2'b01: if (idx == 13 + t_d) v = 1'b1;
      2'b00: begin
        if (idx == 5 + t_d) v = 1'b1;
        else if (idx >= 6 + t_d && idx <= 13 + t_d) v = t_b[idx-6-t_d];
      end
      default: v = 1'b0;
    endcase
    return v;
  endfunction

  always @(negedge ck_o) begin
    dat_i <= tgt_bit(fall_total - fall_base);
    fall_total = fall_total + 1;
  end

  always @(posedge ck_o) begin
    if (dat_oe === 1'b1) begin
      cap = {cap[30:0], dat_o};
      cap_total = cap_total + 1;
    end
  end

  // ---------------- monitor / scoreboard ----------------
  int lo_run = 0, hi_run = 0, max_lo = 0, max_hi = 0, min_hi = 1000;
  int dcount = 0;
  bit prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ck_o === 1'b0) lo_run++;
      else begin
        if (lo_run > max_lo) max_lo = lo_run;
        lo_run = 0;
      end
      if (busy && ck_o) hi_run++;
      else begin
        if (busy && hi_run > 0) begin
          if (hi_run > max_hi) max_hi = hi_run;
          if (hi_run < min_hi) min_hi = hi_run;
        end
        hi_run = 0;
      end
      if (prev_done) chk(done == 1'b0, "R11", "done pulse width", done, 0);
      prev_done = done;
      if (done) begin
        dcount++;
        if (sbq.size() == 0) begin
          chk(1'b0, "R12", "unexpected done", 1, 0);
        end else begin
          item_t it;
          string tg;
          int fs, nb;
          logic [31:0] mask;
          it = sbq.pop_front();
          tg = tagq.pop_front();
          fs = fall_total - fall_base;
          nb = cap_total - cap_base;
          mask = (32'd1 << nb) - 32'd1;
          chk(fs == it.strobes, tg, "strobe count", fs, it.strobes);
          chk(nb == it.nbits, tg, "R3 driven bit count", nb, it.nbits);
          chk((cap & mask) == it.bits, tg, "R3 driven bit pattern",
              cap & mask, it.bits);
          chk(err == it.err, tg, "R11 err flag", err, it.err);
          chk(rd_byte == it.rd, tg, "R11 rd_byte", rd_byte, it.rd);
          if (it.is_rst)
            chk(max_lo == it.lo, "R10", "reset low length", max_lo, it.lo);
          else begin
            chk(max_lo == HALF, "R9", "longest low phase", max_lo, HALF);
            chk(max_hi == HALF && min_hi == HALF, "R9", "high phase length",
                max_hi, HALF);
          end
        end
        max_lo = 0; max_hi = 0; min_hi = 1000;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic issue_frame(input logic [1:0] op, input logic [7:0] b,
                             input int d, input string tag);
    item_t it;
    bit to;
    to = (d >= WLIM);
    it.is_rst = 1'b0; it.lo = HALF; it.err = 1'b0; it.bits = '0;
    case (op)
      2'b11: begin it.strobes = 12; it.nbits = 10;
                   it.bits = {22'd0, 2'b11, b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]}; end
      2'b10: begin it.strobes = 12; it.nbits = 2; it.bits = 32'b01; last_rd = b; end
      2'b01: begin it.nbits = 12;
                   it.bits = {20'd0, 4'b1000, b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
                   it.strobes = to ? 33 : 15 + d; it.err = to; end
      default: begin it.nbits = 4; it.bits = 32'b0000;
                   it.strobes = to ? 25 : 15 + d; it.err = to;
                   if (!to) last_rd = b; end
    endcase
    it.rd = last_rd;
    sbq.push_back(it); tagq.push_back(tag);
    t_op = op; t_b = b; t_d = d;
    fall_base = fall_total; cap_base = cap_total;
    req_op = op; req_byte = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int start);
    while (dcount == start) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_frame(input logic [1:0] op, input logic [7:0] b,
                          input int d, input string tag);
    int s;
    s = dcount;
    issue_frame(op, b, d, tag);
    wait_done(s);
  endtask

  task automatic do_reset(input bit with_req, input string tag);
    item_t it;
    int s;
    it.is_rst = 1'b1; it.strobes = 1; it.nbits = 0; it.bits = '0;
    it.err = 1'b0; it.rd = last_rd; it.lo = RSTT * HALF;
    sbq.push_back(it); tagq.push_back(tag);
    t_op = 2'b11;
    fall_base = fall_total; cap_base = cap_total;
    s = dcount;
    rst_req = 1'b1;
    if (with_req) begin req_op = 2'b00; req_byte = 8'h77; req_valid = 1'b1; end
    @(negedge clk);
    rst_req = 1'b0; req_valid = 1'b0;
    wait_done(s);
  endtask

  initial begin
    rst_n = 1'b0; port_en = 1'b0; req_valid = 1'b0; rst_req = 1'b0;
    req_op = 2'b00; req_byte = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(ck_oe == 1'b0 && dat_oe == 1'b0, "R1", "enables after reset", {ck_oe, dat_oe}, 0);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
    chk(ck_o == 1'b1, "R1", "clock level after reset", ck_o, 1);

    // R12 request while disabled
    begin
      bit saw;
      saw = 1'b0;
      req_op = 2'b11; req_byte = 8'h55; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (60) begin
        if (busy) saw = 1'b1;
        @(negedge clk);
      end
      chk(!saw && dcount == 0, "R12", "request while disabled", saw, 0);
    end

    // R2 enable ordering
    port_en = 1'b1;
    chk(ck_oe == 1'b0, "R2", "ck_oe before edge", ck_oe, 0);
    @(negedge clk);
    chk(ck_oe == 1'b1 && ck_o == 1'b1 && dat_oe == 1'b0, "R2",
        "clock high, data released at enable", {ck_oe, ck_o, dat_oe}, 3'b110);
    repeat (2) @(negedge clk);

    do_frame(2'b11, 8'hA5, 0,  "R4");
    do_frame(2'b10, 8'h3C, 0,  "R5");
    do_frame(2'b01, 8'h96, 0,  "R6");
    do_frame(2'b01, 8'h0F, 19, "R6");
    do_frame(2'b00, 8'h5A, 0,  "R7");
    do_frame(2'b00, 8'hC3, 7,  "R7");
    do_frame(2'b01, 8'h33, 99, "R8");
    do_frame(2'b00, 8'hE1, 99, "R8");
    do_frame(2'b10, 8'h81, 0,  "R5");
    do_reset(1'b0, "R10");

    // R12 request during a busy frame
    begin
      int s;
      s = dcount;
      issue_frame(2'b11, 8'h6E, 0, "R12");
      repeat (10) @(negedge clk);
      req_op = 2'b00; req_byte = 8'hFF; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(s);
      repeat (150) @(negedge clk);
      chk(dcount == s + 1 && busy == 1'b0, "R12", "request while busy",
          dcount - s, 1);
    end

    // R10 reset beats a frame request in the same cycle
    do_reset(1'b1, "R10");
    chk(sbq.size() == 0, "R10", "pending items", sbq.size(), 0);

    // R1 disable
    port_en = 1'b0;
    @(negedge clk);
    chk(ck_oe == 1'b0 && dat_oe == 1'b0, "R1", "enables after disable",
        {ck_oe, dat_oe}, 0);

    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule